// File: doc/BRIEF.md
# Serial Debug Command Engine

This block takes debug commands from a host over a synchronous full-duplex serial link. The link runs on a bit strobe in the core clock domain. The host sends 16-bit words, most significant bit first. The engine builds each command from an operation word followed by zero or more extension words. It runs the command as soon as the last word arrives. Commands can read or write a general register through a small register-file port, and read or write two address-space code registers. They can read or write memory at a 32-bit address with byte, word or long size, and step through a block of memory with a dump or fill command that carries no address. Other commands pulse a peripheral reset output, or do nothing.

Results are not sent back at once. They wait in a small result holder and are shifted out while the host sends the next word or words. A long result takes two words, high word first, so the host usually follows a read with one or two null commands. When there is no result to send, the engine sends 0x0000. This covers an incomplete command and a memory access still waiting for its ready.

The controller is a four-state machine. The states are IDLE (waiting for an operation word), EXT (collecting extension words), EXEC (a single cycle that performs the command) and MEM (holding a memory request until ready). The transitions are:
- IDLE→EXT when the operation word needs extension words.
- IDLE→EXEC when it needs none.
- EXT→EXEC on the last extension word.
- EXEC→MEM for a memory access.
- EXEC→IDLE for every other command and for a block error.
- MEM→IDLE on the ready cycle.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset, `sdo` is 0, `periph_rst` and `mem_req` are low, and no result is pending, so a null command shifts out 0x0000.
- R2: Each word is 16 bits, most significant bit first. A bit of `sdi` is taken on each cycle where `sclk_en` is high. `sdo` shows the next outgoing bit before the strobe that consumes it.
- R3: The operation word has the opcode in bits [15:12], the size in bits [7:6] (0 byte, 1 word, 2 or 3 long) and the select field in bits [3:0]. The opcodes are:
  - 0 null
  - 1 register read
  - 2 register write
  - 3 code read
  - 4 code write
  - 5 memory read
  - 6 memory write
  - 7 dump
  - 8 fill
  - 9 peripheral reset
  - all other values act as null.
- R4: Register write takes two extension words (data high, then low) and writes register `sel` once. Register read returns the 32-bit register as two words, high first, in the two words shifted after the command.
- R5: Code write takes two data words. Select 0 sets the read-space code and select 1 sets the write-space code, keeping the low 3 bits. Code read returns the selected code zero-extended to 32 bits as two words.
- R6: Memory read takes two address words, high first, and drives `mem_fc` with the read-space code. A byte result returns as {0x00, byte}, a word result as one word, and a long result as two words, high first.
- R7: Memory write takes two address words, then the data: one word for byte or word size, two for long. It drives `mem_fc` with the write-space code.
- R8: Dump reads, and fill writes, at the previous block address plus 1, 2 or 4 for byte, word or long size. Fill takes one data word, or two for long size. Each access becomes the new block address.
- R9: Dump is allowed only when the last successful memory access was a read, and fill only when it was a write. Otherwise the command makes no memory access and returns the single word 0xFFFF.
- R10: While a command is incomplete or a memory access waits for `mem_ready`, words shifted out read 0x0000. A word received during the memory wait is discarded.
- R11: The peripheral reset command drives `periph_rst` high for exactly 512 cycles. Register and memory commands keep working during the pulse.
- R12: A null command changes no register, memory or output and only shifts out any pending result.
- R13: `mem_req` stays high with `mem_addr` and `mem_we` stable until the cycle in which `mem_ready` is high. It is low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_en | input | 1 | Serial bit strobe |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| mem_req | output | 1 | Memory request, held until ready |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_fc | output | 3 | Address-space code |
| mem_size | output | 2 | Access size (0 byte, 1 word, 2/3 long) |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned |
| mem_ready | input | 1 | Access complete |
| reg_sel | output | 4 | Register select |
| reg_we | output | 1 | Register write strobe |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data |
| periph_rst | output | 1 | Peripheral reset pulse |

## Verification
The bench aims at the result-timing edge: a result must appear in the word after its command. A design that loaded the output register when the command word ended would send 0x0000 where data is due. It targets block context: a dump after a write, or a fill after a read, must return 0xFFFF and leave memory untouched. A design without this check would touch an address derived from stale state. It checks the block step per size, where a wrong increment reads or writes the wrong byte. It checks the memory-wait window, where a design that accepts a reset command word would raise `periph_rst`, and the reset pulse length, where an off-by-one counter gives 511 or 513 cycles.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam int WORD_W = 16;
    localparam int BIT_W  = $clog2(WORD_W);

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_RDREG = 4'd1,
        OP_WRREG = 4'd2,
        OP_RDSYS = 4'd3,
        OP_WRSYS = 4'd4,
        OP_READ  = 4'd5,
        OP_WRITE = 4'd6,
        OP_DUMP  = 4'd7,
        OP_FILL  = 4'd8,
        OP_PRST  = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LNG2 = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EXT,
        S_EXEC,
        S_MEM
    } state_e;

    function automatic logic is_long(input logic [1:0] sz);
        return sz[1];
    endfunction

    // number of extension words a command needs
    function automatic logic [2:0] ext_words(input logic [3:0] op, input logic [1:0] sz);
        case (op)
            OP_WRREG, OP_WRSYS, OP_READ: return 3'd2;
            OP_WRITE: return is_long(sz) ? 3'd4 : 3'd3;
            OP_FILL:  return is_long(sz) ? 3'd2 : 3'd1;
            default:  return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dbg_serial.sv
module dbg_serial
    import dbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_en,
    input  logic              sdi,
    input  logic [WORD_W-1:0] tx_word,
    output logic              sdo,
    output logic              tx_pop,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    logic [BIT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] tx_sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= 1'b0;
            if (sclk_en) begin
                rx_sh   <= {rx_sh[WORD_W-2:0], sdi};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == '0)
                    tx_sh <= {tx_word[WORD_W-2:0], 1'b0};
                else
                    tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                if (bit_cnt == LAST_BIT) begin
                    word_valid <= 1'b1;
                    word_data  <= {rx_sh[WORD_W-2:0], sdi};
                end
            end
        end
    end

    // the outgoing word is chosen at the first bit of each frame
    assign tx_pop = sclk_en && (bit_cnt == '0);
    assign sdo    = (bit_cnt == '0) ? tx_word[WORD_W-1] : tx_sh[WORD_W-1];

    // R2
    word_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(sclk_en));

endmodule

// File: rtl/dbg_rst_timer.sv
module dbg_rst_timer #(
    parameter int CYCLES = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic pulse
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (go)
            cnt <= CW'(CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign pulse = (cnt != '0);

    // R11
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> pulse);

    // R11
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !go && cnt == CW'(1)) |=> !pulse);

endmodule

// File: rtl/dbg_ctrl.sv
module dbg_ctrl
    import dbg_pkg::*;
#(
    parameter int AW  = 32,
    parameter int FCW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              tx_pop,
    output logic [WORD_W-1:0] tx_word,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [FCW-1:0]    mem_fc,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready,
    output logic [3:0]        reg_sel,
    output logic              reg_we,
    output logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_rdata,
    output logic              rst_go
);

    localparam int EXT_W = 4 * WORD_W;

    state_e st, st_nx;

    logic [3:0]       op_q;
    logic [1:0]       sz_q;
    logic [3:0]       sel_q;
    logic [2:0]       ext_need;
    logic [2:0]       ext_cnt;
    logic [EXT_W-1:0] ext_q;
    logic [AW-1:0]    blk_addr;
    logic [AW-1:0]    addr_q;
    logic [31:0]      wdata_q;
    logic             we_q;
    logic [FCW-1:0]   rd_fc;
    logic [FCW-1:0]   wr_fc;
    logic             rd_ctx;
    logic             wr_ctx;
    logic [31:0]      res_q;
    logic [1:0]       res_n;

    logic [AW-1:0]    step;
    logic [AW-1:0]    next_blk;
    logic [31:0]      op_data;
    logic             go_mem;

    always_comb begin
        unique case (sz_q)
            SZ_BYTE: step = AW'(1);
            SZ_WORD: step = AW'(2);
            default: step = AW'(4);
        endcase
        next_blk = blk_addr + step;
        op_data  = is_long(sz_q) ? ext_q[31:0] : {16'h0000, ext_q[15:0]};
        go_mem   = (op_q == OP_READ) || (op_q == OP_WRITE) ||
                   (op_q == OP_DUMP && rd_ctx) || (op_q == OP_FILL && wr_ctx);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state and command outputs
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (word_valid)
                        st_nx = (ext_words(word_data[15:12], word_data[7:6]) != 3'd0) ? S_EXT : S_EXEC;
            S_EXT:  if (word_valid && ext_cnt == ext_need - 3'd1)
                        st_nx = S_EXEC;
            S_EXEC: st_nx = go_mem ? S_MEM : S_IDLE;
            S_MEM:  if (mem_ready)
                        st_nx = S_IDLE;
        endcase
        mem_req   = (st == S_MEM);
        mem_we    = we_q;
        mem_addr  = addr_q;
        mem_fc    = we_q ? wr_fc : rd_fc;
        mem_size  = sz_q;
        mem_wdata = wdata_q;
        reg_sel   = sel_q;
        reg_we    = (st == S_EXEC) && (op_q == OP_WRREG);
        reg_wdata = ext_q[31:0];
        rst_go    = (st == S_EXEC) && (op_q == OP_PRST);
        unique case (res_n)
            2'd2:    tx_word = res_q[31:16];
            2'd1:    tx_word = res_q[15:0];
            default: tx_word = '0;
        endcase
    end

    // command datapath and result holder
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= '0;
            sz_q     <= '0;
            sel_q    <= '0;
            ext_need <= '0;
            ext_cnt  <= '0;
            ext_q    <= '0;
            blk_addr <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            we_q     <= 1'b0;
            rd_fc    <= '0;
            wr_fc    <= '0;
            rd_ctx   <= 1'b0;
            wr_ctx   <= 1'b0;
            res_q    <= '0;
            res_n    <= '0;
        end else begin
            if (tx_pop && res_n != 2'd0)
                res_n <= res_n - 2'd1;
            unique case (st)
                S_IDLE: if (word_valid) begin
                    op_q     <= word_data[15:12];
                    sz_q     <= word_data[7:6];
                    sel_q    <= word_data[3:0];
                    ext_need <= ext_words(word_data[15:12], word_data[7:6]);
                    ext_cnt  <= '0;
                end
                S_EXT: if (word_valid) begin
                    ext_q   <= {ext_q[EXT_W-WORD_W-1:0], word_data};
                    ext_cnt <= ext_cnt + 3'd1;
                end
                S_EXEC: begin
                    case (op_q)
                        OP_RDREG: begin
                            res_q <= reg_rdata;
                            res_n <= 2'd2;
                        end
                        OP_RDSYS: begin
                            if (sel_q == 4'd0)      res_q <= 32'(rd_fc);
                            else if (sel_q == 4'd1) res_q <= 32'(wr_fc);
                            else                    res_q <= '0;
                            res_n <= 2'd2;
                        end
                        OP_WRSYS: begin
                            if (sel_q == 4'd0) rd_fc <= ext_q[FCW-1:0];
                            if (sel_q == 4'd1) wr_fc <= ext_q[FCW-1:0];
                        end
                        OP_READ: begin
                            addr_q   <= ext_q[AW-1:0];
                            blk_addr <= ext_q[AW-1:0];
                            we_q     <= 1'b0;
                            rd_ctx   <= 1'b1;
                            wr_ctx   <= 1'b0;
                        end
                        OP_WRITE: begin
                            if (is_long(sz_q)) begin
                                addr_q   <= ext_q[32+AW-1:32];
                                blk_addr <= ext_q[32+AW-1:32];
                            end else begin
                                addr_q   <= ext_q[16+AW-1:16];
                                blk_addr <= ext_q[16+AW-1:16];
                            end
                            wdata_q <= op_data;
                            we_q    <= 1'b1;
                            rd_ctx  <= 1'b0;
                            wr_ctx  <= 1'b1;
                        end
                        OP_DUMP: begin
                            if (rd_ctx) begin
                                addr_q   <= next_blk;
                                blk_addr <= next_blk;
                                we_q     <= 1'b0;
                            end else begin
                                res_q <= 32'h0000_FFFF;
                                res_n <= 2'd1;
                            end
                        end
                        OP_FILL: begin
                            if (wr_ctx) begin
                                addr_q   <= next_blk;
                                blk_addr <= next_blk;
                                wdata_q  <= op_data;
                                we_q     <= 1'b1;
                            end else begin
                                res_q <= 32'h0000_FFFF;
                                res_n <= 2'd1;
                            end
                        end
                        default: ;
                    endcase
                end
                S_MEM: if (mem_ready && !we_q) begin
                    unique case (sz_q)
                        SZ_BYTE: begin res_q <= {24'h0, mem_rdata[7:0]};  res_n <= 2'd1; end
                        SZ_WORD: begin res_q <= {16'h0, mem_rdata[15:0]}; res_n <= 2'd1; end
                        default: begin res_q <= mem_rdata;                res_n <= 2'd2; end
                    endcase
                end
            endcase
        end
    end

    // R13
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R13
    mem_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> !mem_req);

    // R9
    dump_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_EXEC && op_q == OP_DUMP && !rd_ctx) |=> (tx_word == 16'hFFFF && !mem_req));

    // R4
    rdreg_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_EXEC && op_q == OP_RDREG) |=> (tx_word == $past(reg_rdata[31:16])));

endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine #(
    parameter int AW         = 32,
    parameter int FCW        = 3,
    parameter int RST_CYCLES = 512
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk_en,
    input  logic           sdi,
    output logic           sdo,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [FCW-1:0] mem_fc,
    output logic [1:0]     mem_size,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata,
    input  logic           mem_ready,
    output logic [3:0]     reg_sel,
    output logic           reg_we,
    output logic [31:0]    reg_wdata,
    input  logic [31:0]    reg_rdata,
    output logic           periph_rst
);

    import dbg_pkg::*;

    logic              word_valid;
    logic [WORD_W-1:0] word_data;
    logic [WORD_W-1:0] tx_word;
    logic              tx_pop;
    logic              rst_go;

    dbg_serial u_serial (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_en    (sclk_en),
        .sdi        (sdi),
        .tx_word    (tx_word),
        .sdo        (sdo),
        .tx_pop     (tx_pop),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    dbg_ctrl #(.AW(AW), .FCW(FCW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_data  (word_data),
        .tx_pop     (tx_pop),
        .tx_word    (tx_word),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_fc     (mem_fc),
        .mem_size   (mem_size),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .reg_sel    (reg_sel),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .rst_go     (rst_go)
    );

    dbg_rst_timer #(.CYCLES(RST_CYCLES)) u_rst_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (rst_go),
        .pulse (periph_rst)
    );

endmodule

// File: tb/dbg_cmd_engine_tb.sv
module dbg_cmd_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_en = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [2:0]  mem_fc;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [3:0]  reg_sel;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        periph_rst;

    always #5 clk = ~clk;

    dbg_cmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .sdi(sdi), .sdo(sdo),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_fc(mem_fc),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_rst(periph_rst)
    );

    int checks = 0;
    int errors = 0;

    // register file model
    logic [31:0] regs [16];
    initial for (int i = 0; i < 16; i++) regs[i] = '0;
    always @(posedge clk) if (reg_we) regs[reg_sel] <= reg_wdata;
    assign reg_rdata = regs[reg_sel];

    // memory model, big-endian bytes, right-aligned data
    logic [7:0] mem [256];
    initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    int lat = 3;
    int wcnt = 0;
    logic [2:0] last_fc = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            wcnt      <= 0;
        end else if (mem_req && !mem_ready) begin
            if (wcnt >= lat) begin
                logic [7:0] a;
                a = mem_addr[7:0];
                mem_ready <= 1'b1;
                wcnt      <= 0;
                last_fc   <= mem_fc;
                if (mem_we) begin
                    if (mem_size == 2'd0) mem[a] <= mem_wdata[7:0];
                    else if (mem_size == 2'd1) begin
                        mem[a] <= mem_wdata[15:8]; mem[a+8'd1] <= mem_wdata[7:0];
                    end else begin
                        mem[a] <= mem_wdata[31:24]; mem[a+8'd1] <= mem_wdata[23:16];
                        mem[a+8'd2] <= mem_wdata[15:8]; mem[a+8'd3] <= mem_wdata[7:0];
                    end
                end else begin
                    if (mem_size == 2'd0) mem_rdata <= {24'h0, mem[a]};
                    else if (mem_size == 2'd1) mem_rdata <= {16'h0, mem[a], mem[a+8'd1]};
                    else mem_rdata <= {mem[a], mem[a+8'd1], mem[a+8'd2], mem[a+8'd3]};
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ready <= 1'b0;
        end
    end

    // reset pulse length counter
    int prst_cycles = 0;
    always @(negedge clk) if (periph_rst) prst_cycles <= prst_cycles + 1;

    // scoreboard
    typedef struct {
        logic [15:0] v;
        string       tag;
    } exp_t;
    exp_t        exp_q[$];
    logic [15:0] got_q[$];

    always @(negedge clk) begin : monitor
        exp_t        e;
        logic [15:0] g;
        if (exp_q.size() > 0 && got_q.size() > 0) begin
            e = exp_q.pop_front();
            g = got_q.pop_front();
            checks++;
            if (g !== e.v) begin
                errors++;
                $display("FAIL %s: got %h expected %h", e.tag, g, e.v);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] w, output logic [15:0] r);
        r = '0;
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            sdi = w[i];
            sclk_en = 1'b1;
            #1 r[i] = sdo;
            @(negedge clk);
            sclk_en = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w, input logic [15:0] e, input string tag);
        exp_t        x;
        logic [15:0] r;
        x.v   = e;
        x.tag = tag;
        exp_q.push_back(x);
        xfer(w, r);
        got_q.push_back(r);
    endtask

    function automatic logic [15:0] opw(input logic [3:0] op, input logic [1:0] sz, input logic [3:0] sel);
        return {op, 4'h0, sz, 2'b00, sel};
    endfunction

    task automatic finish_run();
        while (exp_q.size() > 0 && got_q.size() > 0) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 sdo", {31'h0, sdo}, 32'h0);
        chk("R1 periph_rst", {31'h0, periph_rst}, 32'h0);
        chk("R1 mem_req", {31'h0, mem_req}, 32'h0);
        send(opw(4'd0, 2'd0, 4'd0), 16'h0000, "R1 R12 null with nothing pending");

        // R4 register write then read (R3 field layout)
        send(opw(4'd2, 2'd0, 4'd5), 16'h0000, "R4 wrreg op");
        send(16'h1234, 16'h0000, "R4 wrreg hi");
        send(16'h5678, 16'h0000, "R2 R4 wrreg lo");
        chk("R4 reg5 written", regs[5], 32'h1234_5678);
        chk("R12 reg4 untouched", regs[4], 32'h0);
        send(opw(4'd1, 2'd0, 4'd5), 16'h0000, "R4 rdreg op");
        send(opw(4'd0, 2'd0, 4'd0), 16'h1234, "R4 R2 rdreg high word");
        send(opw(4'd0, 2'd0, 4'd0), 16'h5678, "R4 rdreg low word");

        // R5 space codes
        send(opw(4'd4, 2'd0, 4'd0), 16'h0000, "R5 wrsys rd code");
        send(16'h0000, 16'h0000, "R5 wrsys hi");
        send(16'h0005, 16'h0000, "R5 wrsys lo");
        send(opw(4'd4, 2'd0, 4'd1), 16'h0000, "R5 wrsys wr code");
        send(16'h0000, 16'h0000, "R5 wrsys hi");
        send(16'h0003, 16'h0000, "R5 wrsys lo");
        send(opw(4'd3, 2'd0, 4'd0), 16'h0000, "R5 rdsys op");
        send(opw(4'd0, 2'd0, 4'd0), 16'h0000, "R5 rdsys high");
        send(opw(4'd0, 2'd0, 4'd0), 16'h0005, "R5 rdsys low rd code");
        send(opw(4'd3, 2'd0, 4'd1), 16'h0000, "R5 rdsys op");
        send(opw(4'd0, 2'd0, 4'd0), 16'h0000, "R5 rdsys high");
        send(opw(4'd0, 2'd0, 4'd0), 16'h0003, "R5 rdsys low wr code");

        // R7 long write at 0x10
        send(opw(4'd6, 2'd2, 4'd0), 16'h0000, "R7 write op");
        send(16'h0000, 16'h0000, "R7 addr hi");
        send(16'h0010, 16'h0000, "R7 addr lo");
        send(16'hDEAD, 16'h0000, "R7 data hi");
        send(16'hBEEF, 16'h0000, "R7 data lo");
        chk("R7 long bytes", {mem[16], mem[17], mem[18], mem[19]}, 32'hDEAD_BEEF);
        chk("R7 write code", {29'h0, last_fc}, 32'h3);

        // R6 word read, R8 word dump
        send(opw(4'd5, 2'd1, 4'd0), 16'h0000, "R6 read op");
        send(16'h0000, 16'h0000, "R6 addr hi");
        send(16'h0010, 16'h0000, "R10 R6 addr lo");
        chk("R6 read code", {29'h0, last_fc}, 32'h5);
        send(opw(4'd7, 2'd1, 4'd0), 16'hDEAD, "R6 word read result");
        send(opw(4'd0, 2'd0, 4'd0), 16'hBEEF, "R8 word dump +2");

        // R6 long read
        send(opw(4'd5, 2'd2, 4'd0), 16'h0000, "R6 long read op");
        send(16'h0000, 16'h0000, "R6 addr hi");
        send(16'h0010, 16'h0000, "R6 addr lo");
        send(opw(4'd0, 2'd0, 4'd0), 16'hDEAD, "R6 long high first");
        send(opw(4'd0, 2'd0, 4'd0), 16'hBEEF, "R6 long low");

        // R7 byte write, R8 byte fills
        send(opw(4'd6, 2'd0, 4'd0), 16'h0000, "R7 byte write op");
        send(16'h0000, 16'h0000, "R7 addr hi");
        send(16'h0020, 16'h0000, "R7 addr lo");
        send(16'h00A5, 16'h0000, "R7 byte data");
        send(opw(4'd8, 2'd0, 4'd0), 16'h0000, "R8 fill op");
        send(16'h005A, 16'h0000, "R8 fill data");
        send(opw(4'd8, 2'd0, 4'd0), 16'h0000, "R8 fill op");
        send(16'h0077, 16'h0000, "R8 fill data");
        chk("R7 byte at 0x20", {24'h0, mem[32]}, 32'hA5);
        chk("R8 fill at 0x21", {24'h0, mem[33]}, 32'h5A);
        chk("R8 fill at 0x22", {24'h0, mem[34]}, 32'h77);

        // R6 byte read, R8 byte dump
        send(opw(4'd5, 2'd0, 4'd0), 16'h0000, "R6 byte read op");
        send(16'h0000, 16'h0000, "R6 addr hi");
        send(16'h0021, 16'h0000, "R6 addr lo");
        send(opw(4'd7, 2'd0, 4'd0), 16'h005A, "R6 byte result zero-extended");
        send(opw(4'd0, 2'd0, 4'd0), 16'h0077, "R8 byte dump +1");

        // R9 fill after a read
        send(opw(4'd8, 2'd0, 4'd0), 16'h0000, "R9 fill op");
        send(16'h0099, 16'h0000, "R9 fill data");
        send(opw(4'd0, 2'd0, 4'd0), 16'hFFFF, "R9 fill without write context");
        chk("R9 no write at 0x23", {24'h0, mem[35]}, 32'h00);

        // R8 long fill, R9 dump after a write
        send(opw(4'd6, 2'd2, 4'd0), 16'h0000, "R7 long write op");
        send(16'h0000, 16'h0000, "R7 addr hi");
        send(16'h0030, 16'h0000, "R7 addr lo");
        send(16'h0102, 16'h0000, "R7 data hi");
        send(16'h0304, 16'h0000, "R7 data lo");
        send(opw(4'd8, 2'd2, 4'd0), 16'h0000, "R8 long fill op");
        send(16'h0506, 16'h0000, "R8 fill hi");
        send(16'h0708, 16'h0000, "R8 fill lo");
        chk("R8 long fill +4", {mem[52], mem[53], mem[54], mem[55]}, 32'h0506_0708);
        send(opw(4'd7, 2'd1, 4'd0), 16'h0000, "R9 dump op");
        send(opw(4'd0, 2'd0, 4'd0), 16'hFFFF, "R9 dump without read context");

        // R10 slow memory: not-ready word, discarded reset command
        lat = 300;
        send(opw(4'd5, 2'd1, 4'd0), 16'h0000, "R10 read op");
        send(16'h0000, 16'h0000, "R10 addr hi");
        send(16'h0034, 16'h0000, "R10 addr lo");
        send(opw(4'd9, 2'd0, 4'd0), 16'h0000, "R10 not ready during wait");
        chk("R10 word during wait discarded", {31'h0, periph_rst}, 32'h0);
        repeat (400) @(negedge clk);
        lat = 3;
        send(opw(4'd0, 2'd0, 4'd0), 16'h0506, "R10 result after ready");

        // R11 reset pulse, engine keeps working
        prst_cycles = 0;
        send(opw(4'd9, 2'd0, 4'd0), 16'h0000, "R11 reset op");
        chk("R11 pulse active", {31'h0, periph_rst}, 32'h1);
        send(opw(4'd1, 2'd0, 4'd5), 16'h0000, "R11 rdreg during pulse");
        send(opw(4'd0, 2'd0, 4'd0), 16'h1234, "R11 engine alive high");
        send(opw(4'd0, 2'd0, 4'd0), 16'h5678, "R11 engine alive low");
        repeat (600) @(negedge clk);
        chk("R11 pulse length", prst_cycles, 32'd512);
        chk("R11 pulse ended", {31'h0, periph_rst}, 32'h0);
        chk("R13 no request left", {31'h0, mem_req}, 32'h0);

        finish_run();
    end

endmodule